// File: doc/BRIEF.md
# Activity-Monitor Event-Type Register Bank

This block holds the event-selection registers for a group of up to sixteen auxiliary activity-monitor counters. Each register is 64 bits wide. Only a 16-bit event-number field is stored; every other bit reads as zero. The bank sits behind a system-register access port. Each access carries the five-part register encoding, a read/write flag, write data, the current exception level, and the control bits that govern trapping.

For every access that falls in its encoding window, the block works out the register index. It checks that the index is in range and implemented, then decides the access in strict priority order. The possible results are:
- return the stored value;
- perform the write;
- declare the access undefined;
- trap it to exception level 1, 2 or 3 with syndrome class 0x18.

The result is registered one cycle after the access strobe.

Some counters have a hard-wired event. Their registers return that event number and never change. Writes are accepted only from the highest implemented exception level. A write that lands on a register whose counter is currently running is accepted but does not change the register, and it sets a sticky warning flag.

Top module: `amon_evtype_bank`

## Requirements
- R1: An access is claimed only when op0=3, op1=3, CRn=13 and CRm[3:1]=3'b111. A claimed access produces exactly one response, with `rsp_vld` high in the cycle after the strobe. An access that is not claimed produces no response. The outcome code is 0=read data, 1=write performed, 2=undefined, 3=trap.
- R2: The index is {CRm[0], op2[2:0]}. The access is undefined when the index is at or above `NUM_CTR`, or when its `IMPL_MASK` bit is 0. This check overrides every trap condition.
- R3: A read from level 0 is decided by the first of these conditions that holds:
  - EL3 is present, the EL3 priority-undefined input is set and the EL3 trap-all bit is set: the access is undefined.
  - The user-access enable is 0: trap to level 2 if EL2 is enabled and host routing is set, otherwise trap to level 1.
  - EL2 is enabled and the EL2 trap-all bit is set: trap to level 2.
  - The qualified fine-grained trap bit is set: trap to level 2.
  - EL3 is present and its trap-all bit is set: the access is undefined if the EL3 undefined input is set, otherwise it traps to level 3.
  - None of the above: return the data.
- R4: Bit m of the fine-grained trap vector counts only for index m. It counts only when EL2 is enabled, fine-grained traps exist, and EL3 is either absent or allows them. At level 0 it additionally requires that level 0 is not running in host mode.
- R5: A read from level 1 uses the order of R3 with the user-access step removed and with no host-mode condition.
- R6: A read from level 2 is subject only to the two EL3 steps of R3. A read from level 3 always returns the data.
- R7: Every trap response carries `rsp_ec`=0x18 and the target level (1, 2 or 3) on `rsp_trap_el`.
- R8: A write is performed only when the current level equals the highest implemented level (3 if EL3 is present, else 2 if EL2 is present, else 1) and the index is not fixed. Every other write is undefined. Trap controls do not affect writes.
- R9: Read data carries the event number in bits 15:0 and zero in bits 63:16. Write data bits 63:16 are discarded.
- R10: An index marked in `FIXED_MASK` always reads its hard-wired event number from `FIXED_EVT`, and writes to it never change it.
- R11: A performed write to index m while `ctr_enable[m]` is 1 leaves the stored value unchanged and sets `enabled_wr_warn`. The flag stays set until reset.
- R12: Synchronous reset clears every writable register and the warning flag. Fixed entries keep their hard-wired value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| el2_present | input | 1 | EL2 is implemented |
| el3_present | input | 1 | EL3 is implemented |
| el2_enabled | input | 1 | EL2 is enabled for the current state |
| host_route | input | 1 | Route level-0 traps to EL2 |
| el0_host | input | 1 | Level 0 runs in host mode |
| user_access_en | input | 1 | Level-0 access enable |
| el2_trap_all | input | 1 | EL2 traps all monitor accesses |
| el3_trap_all | input | 1 | EL3 traps all monitor accesses |
| fgt_present | input | 1 | Fine-grained traps are implemented |
| el3_fgt_allow | input | 1 | EL3 allows fine-grained traps |
| fgt_trap_vec | input | 16 | Per-index fine-grained trap bits |
| el3_undef_prio | input | 1 | EL3 undefined takes top priority |
| el3_undef | input | 1 | EL3 trap becomes undefined |
| ctr_enable | input | 16 | Per-index counter running |
| rsp_vld | output | 1 | Response valid |
| rsp_kind | output | 2 | Outcome code |
| rsp_rdata | output | 64 | Read data |
| rsp_trap_el | output | 2 | Trap target level |
| rsp_ec | output | 6 | Trap syndrome class |
| enabled_wr_warn | output | 1 | Sticky write-while-running flag |

## Verification
The bench sets up pairs of trap conditions that are true at the same time and checks which one wins. For example, it makes the user-enable trap and the EL3 priority-undefined condition hold together; a design with the priority order wrong would return the lower-ranked outcome. It drives out-of-range and unimplemented indices while trap bits are set; a design that checked traps first would report a trap instead of undefined. It toggles the host-mode, EL3-absent and fine-grained-enable qualifiers one at a time; a design that ignored one of them would trap reads that should pass, or pass reads that should trap. It also writes:
- to the fixed entry;
- from a level below the highest;
- to a running counter;
- with all-ones upper data bits.

It then reads each of these back, which exposes any lost masking or any stray update.

// File: rtl/amon_evtype_pkg.sv
package amon_evtype_pkg;

    localparam int MAX_IDX = 16;
    localparam int IDX_W   = $clog2(MAX_IDX);
    localparam int REG_W   = 64;
    localparam int EVT_W   = 16;
    localparam int EC_W    = 6;
    localparam int LVL_W   = 2;

    localparam logic [EC_W-1:0] EC_SYSREG = 6'h18;

    // encoding window owned by the bank
    localparam logic [1:0] WIN_OP0 = 2'b11;
    localparam logic [2:0] WIN_OP1 = 3'b011;
    localparam logic [3:0] WIN_CRN = 4'b1101;
    localparam logic [2:0] WIN_CRM = 3'b111;

    typedef enum logic [1:0] {
        OUT_READ  = 2'd0,
        OUT_WRITE = 2'd1,
        OUT_UNDEF = 2'd2,
        OUT_TRAP  = 2'd3
    } outcome_e;

    typedef enum logic [LVL_W-1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } level_e;

    typedef struct packed {
        logic el2_present;
        logic el3_present;
        logic el2_en;
        logic host_route;
        logic el0_host;
        logic user_en;
        logic el2_trap_all;
        logic el3_trap_all;
        logic fgt_impl;
        logic el3_fgt_allow;
        logic el3_undef_prio;
        logic el3_undef;
    } ctl_t;

    typedef struct packed {
        outcome_e   kind;
        level_e     trap_el;
    } verdict_t;

    function automatic logic in_window(input logic [1:0] op0, input logic [2:0] op1,
                                       input logic [3:0] crn, input logic [3:0] crm);
        return (op0 == WIN_OP0) && (op1 == WIN_OP1) && (crn == WIN_CRN) &&
               (crm[3:1] == WIN_CRM);
    endfunction

    function automatic logic [IDX_W-1:0] index_of(input logic [3:0] crm, input logic [2:0] op2);
        return {crm[0], op2};
    endfunction

    function automatic level_e top_level(input logic el2p, input logic el3p);
        if (el3p)      return LVL3;
        else if (el2p) return LVL2;
        else           return LVL1;
    endfunction

    function automatic verdict_t make_trap(input level_e lvl);
        verdict_t v;
        v.kind    = OUT_TRAP;
        v.trap_el = lvl;
        return v;
    endfunction

    function automatic verdict_t make_plain(input outcome_e k);
        verdict_t v;
        v.kind    = k;
        v.trap_el = LVL0;
        return v;
    endfunction

endpackage

// File: rtl/amon_evtype_decode.sv
module amon_evtype_decode
    import amon_evtype_pkg::*;
#(
    parameter int                 NUM_CTR   = 12,
    parameter logic [MAX_IDX-1:0] IMPL_MASK = 16'hFF7F
) (
    input  logic [1:0]       op0,
    input  logic [2:0]       op1,
    input  logic [3:0]       crn,
    input  logic [3:0]       crm,
    input  logic [2:0]       op2,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic             idx_ok
);

    logic [MAX_IDX-1:0] usable;

    // one usable bit per slot: below the configured count and implemented
    for (genvar i = 0; i < MAX_IDX; i++) begin : g_use
        if (i < NUM_CTR) begin : g_in
            assign usable[i] = IMPL_MASK[i];
        end else begin : g_out
            assign usable[i] = 1'b0;
        end
    end

    always_comb begin
        hit    = in_window(op0, op1, crn, crm);
        idx    = index_of(crm, op2);
        idx_ok = usable[idx];
    end

endmodule

// File: rtl/amon_evtype_perm.sv
module amon_evtype_perm
    import amon_evtype_pkg::*;
(
    input  logic             is_wr,
    input  level_e           cur_lvl,
    input  logic             idx_ok,
    input  logic             fixed_bit,
    input  logic             fgt_bit,
    input  ctl_t             ctl,
    output verdict_t         verdict
);

    logic   el3_gate;
    logic   el3_first;
    logic   el2_gate;
    logic   fgt_any;
    logic   fgt_el0;
    level_e user_tgt;
    level_e high_lvl;

    always_comb begin
        el3_gate  = ctl.el3_present && ctl.el3_trap_all;
        el3_first = el3_gate && ctl.el3_undef_prio;
        el2_gate  = ctl.el2_en && ctl.el2_trap_all;
        fgt_any   = ctl.el2_en && ctl.fgt_impl &&
                    (!ctl.el3_present || ctl.el3_fgt_allow) && fgt_bit;
        fgt_el0   = fgt_any && !ctl.el0_host;
        user_tgt  = (ctl.el2_en && ctl.host_route) ? LVL2 : LVL1;
        high_lvl  = top_level(ctl.el2_present, ctl.el3_present);
    end

    function automatic verdict_t el3_tail();
        if (el3_gate) begin
            if (ctl.el3_undef) return make_plain(OUT_UNDEF);
            else               return make_trap(LVL3);
        end
        return make_plain(OUT_READ);
    endfunction

    always_comb begin
        verdict = make_plain(OUT_UNDEF);
        if (!idx_ok) begin
            verdict = make_plain(OUT_UNDEF);
        end else if (is_wr) begin
            if ((cur_lvl == high_lvl) && !fixed_bit) verdict = make_plain(OUT_WRITE);
            else                                     verdict = make_plain(OUT_UNDEF);
        end else begin
            unique case (cur_lvl)
                LVL3: verdict = make_plain(OUT_READ);
                LVL2: begin
                    if (el3_first) verdict = make_plain(OUT_UNDEF);
                    else           verdict = el3_tail();
                end
                LVL1: begin
                    if (el3_first)    verdict = make_plain(OUT_UNDEF);
                    else if (el2_gate) verdict = make_trap(LVL2);
                    else if (fgt_any)  verdict = make_trap(LVL2);
                    else               verdict = el3_tail();
                end
                default: begin
                    if (el3_first)          verdict = make_plain(OUT_UNDEF);
                    else if (!ctl.user_en)  verdict = make_trap(user_tgt);
                    else if (el2_gate)      verdict = make_trap(LVL2);
                    else if (fgt_el0)       verdict = make_trap(LVL2);
                    else                    verdict = el3_tail();
                end
            endcase
        end
    end

endmodule

// File: rtl/amon_evtype_store.sv
module amon_evtype_store
    import amon_evtype_pkg::*;
#(
    parameter int                       NUM_CTR    = 12,
    parameter logic [MAX_IDX-1:0]       IMPL_MASK  = 16'hFF7F,
    parameter logic [MAX_IDX-1:0]       FIXED_MASK = 16'h0004,
    parameter logic [MAX_IDX*EVT_W-1:0] FIXED_EVT  = 256'h0123 << 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_req,
    input  logic [IDX_W-1:0]   idx,
    input  logic [EVT_W-1:0]   wr_evt,
    input  logic [MAX_IDX-1:0] ctr_enable,
    output logic [EVT_W-1:0]   rd_evt,
    output logic               wr_blocked
);

    logic [MAX_IDX*EVT_W-1:0] slots;
    logic                     commit;

    assign wr_blocked = wr_req && ctr_enable[idx];
    assign commit     = wr_req && !ctr_enable[idx];

    for (genvar i = 0; i < MAX_IDX; i++) begin : g_slot
        if (FIXED_MASK[i]) begin : g_fixed
            assign slots[i*EVT_W +: EVT_W] = FIXED_EVT[i*EVT_W +: EVT_W];
        end else if (IMPL_MASK[i] && (i < NUM_CTR)) begin : g_reg
            logic [EVT_W-1:0] evt_q;
            always_ff @(posedge clk) begin
                if (rst)
                    evt_q <= '0;
                else if (commit && (idx == IDX_W'(i)))
                    evt_q <= wr_evt;
            end
            assign slots[i*EVT_W +: EVT_W] = evt_q;
        end else begin : g_absent
            assign slots[i*EVT_W +: EVT_W] = '0;
        end
    end

    assign rd_evt = slots[idx*EVT_W +: EVT_W];

endmodule

// File: rtl/amon_evtype_bank.sv
module amon_evtype_bank
    import amon_evtype_pkg::*;
#(
    parameter int                       NUM_CTR    = 12,
    parameter logic [MAX_IDX-1:0]       IMPL_MASK  = 16'hFF7F,
    parameter logic [MAX_IDX-1:0]       FIXED_MASK = 16'h0004,
    parameter logic [MAX_IDX*EVT_W-1:0] FIXED_EVT  = 256'h0123 << 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_vld,
    input  logic               acc_wr,
    input  logic [1:0]         acc_op0,
    input  logic [2:0]         acc_op1,
    input  logic [3:0]         acc_crn,
    input  logic [3:0]         acc_crm,
    input  logic [2:0]         acc_op2,
    input  logic [63:0]        acc_wdata,
    input  logic [1:0]         cur_el,
    input  logic               el2_present,
    input  logic               el3_present,
    input  logic               el2_enabled,
    input  logic               host_route,
    input  logic               el0_host,
    input  logic               user_access_en,
    input  logic               el2_trap_all,
    input  logic               el3_trap_all,
    input  logic               fgt_present,
    input  logic               el3_fgt_allow,
    input  logic [15:0]        fgt_trap_vec,
    input  logic               el3_undef_prio,
    input  logic               el3_undef,
    input  logic [15:0]        ctr_enable,
    output logic               rsp_vld,
    output logic [1:0]         rsp_kind,
    output logic [63:0]        rsp_rdata,
    output logic [1:0]         rsp_trap_el,
    output logic [5:0]         rsp_ec,
    output logic               enabled_wr_warn
);

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    ctl_t             ctl;
    verdict_t         verdict;
    logic [EVT_W-1:0] rd_evt;
    logic             wr_req;
    logic             wr_blocked;
    logic             claim;

    always_comb begin
        ctl.el2_present    = el2_present;
        ctl.el3_present    = el3_present;
        ctl.el2_en         = el2_enabled;
        ctl.host_route     = host_route;
        ctl.el0_host       = el0_host;
        ctl.user_en        = user_access_en;
        ctl.el2_trap_all   = el2_trap_all;
        ctl.el3_trap_all   = el3_trap_all;
        ctl.fgt_impl       = fgt_present;
        ctl.el3_fgt_allow  = el3_fgt_allow;
        ctl.el3_undef_prio = el3_undef_prio;
        ctl.el3_undef      = el3_undef;
    end

    amon_evtype_decode #(
        .NUM_CTR   (NUM_CTR),
        .IMPL_MASK (IMPL_MASK)
    ) u_decode (
        .op0    (acc_op0),
        .op1    (acc_op1),
        .crn    (acc_crn),
        .crm    (acc_crm),
        .op2    (acc_op2),
        .hit    (hit),
        .idx    (idx),
        .idx_ok (idx_ok)
    );

    amon_evtype_perm u_perm (
        .is_wr     (acc_wr),
        .cur_lvl   (level_e'(cur_el)),
        .idx_ok    (idx_ok),
        .fixed_bit (FIXED_MASK[idx]),
        .fgt_bit   (fgt_trap_vec[idx]),
        .ctl       (ctl),
        .verdict   (verdict)
    );

    assign claim  = acc_vld && hit;
    assign wr_req = claim && acc_wr && (verdict.kind == OUT_WRITE);

    amon_evtype_store #(
        .NUM_CTR    (NUM_CTR),
        .IMPL_MASK  (IMPL_MASK),
        .FIXED_MASK (FIXED_MASK),
        .FIXED_EVT  (FIXED_EVT)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .idx        (idx),
        .wr_evt     (acc_wdata[EVT_W-1:0]),
        .ctr_enable (ctr_enable),
        .rd_evt     (rd_evt),
        .wr_blocked (wr_blocked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld         <= 1'b0;
            rsp_kind        <= OUT_READ;
            rsp_rdata       <= '0;
            rsp_trap_el     <= LVL0;
            rsp_ec          <= '0;
            enabled_wr_warn <= 1'b0;
        end else begin
            rsp_vld     <= claim;
            rsp_kind    <= verdict.kind;
            rsp_trap_el <= verdict.trap_el;
            rsp_ec      <= (verdict.kind == OUT_TRAP) ? EC_SYSREG : '0;
            rsp_rdata   <= (verdict.kind == OUT_READ) ?
                           {{(REG_W-EVT_W){1'b0}}, rd_evt} : '0;
            if (wr_blocked)
                enabled_wr_warn <= 1'b1;
        end
    end

endmodule

// File: rtl/amon_evtype_chk.sv
module amon_evtype_chk
    import amon_evtype_pkg::*;
#(
    parameter int                 NUM_CTR   = 12,
    parameter logic [MAX_IDX-1:0] IMPL_MASK = 16'hFF7F
) (
    input logic        clk,
    input logic        rst,
    input logic        acc_vld,
    input logic        acc_wr,
    input logic [3:0]  acc_crm,
    input logic [2:0]  acc_op2,
    input logic [1:0]  cur_el,
    input logic        el2_present,
    input logic        el3_present,
    input logic        rsp_vld,
    input logic [1:0]  rsp_kind,
    input logic [63:0] rsp_rdata,
    input logic [1:0]  rsp_trap_el,
    input logic [5:0]  rsp_ec,
    input logic        enabled_wr_warn
);

    logic [IDX_W-1:0] a_idx;
    logic             a_idx_good;
    assign a_idx      = {acc_crm[0], acc_op2};
    assign a_idx_good = (int'(a_idx) < NUM_CTR) && IMPL_MASK[a_idx];

    assert_rsp_after_acc_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> $past(acc_vld));

    assert_bad_index_undef_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !a_idx_good) |=> (!rsp_vld || rsp_kind == OUT_UNDEF));

    assert_el3_read_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !acc_wr && cur_el == 2'd3 && a_idx_good) |=>
        (!rsp_vld || rsp_kind == OUT_READ));

    assert_trap_class_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_kind == OUT_TRAP) |-> (rsp_ec == EC_SYSREG && rsp_trap_el != 2'd0));

    assert_write_level_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_kind == OUT_WRITE) |->
        ($past(acc_wr) && $past(cur_el) == top_level($past(el2_present), $past(el3_present))));

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> (rsp_rdata[63:16] == 48'd0));

    assert_warn_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        enabled_wr_warn |=> enabled_wr_warn);

endmodule

bind amon_evtype_bank amon_evtype_chk #(
    .NUM_CTR   (NUM_CTR),
    .IMPL_MASK (IMPL_MASK)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .acc_vld         (acc_vld),
    .acc_wr          (acc_wr),
    .acc_crm         (acc_crm),
    .acc_op2         (acc_op2),
    .cur_el          (cur_el),
    .el2_present     (el2_present),
    .el3_present     (el3_present),
    .rsp_vld         (rsp_vld),
    .rsp_kind        (rsp_kind),
    .rsp_rdata       (rsp_rdata),
    .rsp_trap_el     (rsp_trap_el),
    .rsp_ec          (rsp_ec),
    .enabled_wr_warn (enabled_wr_warn)
);

// File: tb/amon_evtype_bank_test.sv
`timescale 1ns/1ps
module amon_evtype_bank_test;

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_UD = 2'd2, K_TR = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_vld = 1'b0, acc_wr = 1'b0;
    logic [1:0]  acc_op0 = 2'd0;
    logic [2:0]  acc_op1 = 3'd0;
    logic [3:0]  acc_crn = 4'd0, acc_crm = 4'd0;
    logic [2:0]  acc_op2 = 3'd0;
    logic [63:0] acc_wdata = 64'd0;
    logic [1:0]  cur_el = 2'd0;
    logic        el2_present = 1, el3_present = 1, el2_enabled = 1, host_route = 0;
    logic        el0_host = 0, user_access_en = 1, el2_trap_all = 0, el3_trap_all = 0;
    logic        fgt_present = 1, el3_fgt_allow = 1, el3_undef_prio = 0, el3_undef = 0;
    logic [15:0] fgt_trap_vec = 16'd0, ctr_enable = 16'd0;
    logic        rsp_vld;
    logic [1:0]  rsp_kind;
    logic [63:0] rsp_rdata;
    logic [1:0]  rsp_trap_el;
    logic [5:0]  rsp_ec;
    logic        enabled_wr_warn;

    always #2 clk = ~clk;

    amon_evtype_bank uut (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
        .acc_op2(acc_op2), .acc_wdata(acc_wdata), .cur_el(cur_el),
        .el2_present(el2_present), .el3_present(el3_present), .el2_enabled(el2_enabled),
        .host_route(host_route), .el0_host(el0_host), .user_access_en(user_access_en),
        .el2_trap_all(el2_trap_all), .el3_trap_all(el3_trap_all), .fgt_present(fgt_present),
        .el3_fgt_allow(el3_fgt_allow), .fgt_trap_vec(fgt_trap_vec),
        .el3_undef_prio(el3_undef_prio), .el3_undef(el3_undef), .ctr_enable(ctr_enable),
        .rsp_vld(rsp_vld), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
        .rsp_trap_el(rsp_trap_el), .rsp_ec(rsp_ec), .enabled_wr_warn(enabled_wr_warn)
    );

    typedef struct {
        logic [1:0]  kind;
        logic [1:0]  tel;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // driver: one strobe, expected item queued for the monitor
    task automatic acc(input bit wr, input int m, input logic [1:0] el,
                       input logic [63:0] wd, input logic [1:0] ek,
                       input logic [1:0] et, input logic [63:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        acc_op0 = 2'b11; acc_op1 = 3'b011; acc_crn = 4'b1101;
        acc_crm = {3'b111, m[3]}; acc_op2 = m[2:0];
        acc_wr = wr; cur_el = el; acc_wdata = wd; acc_vld = 1'b1;
        e.kind = ek; e.tel = et; e.data = ed; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        acc_vld = 1'b0;
    endtask

    task automatic rd(input int m, input logic [1:0] el, input logic [1:0] ek,
                      input logic [1:0] et, input logic [63:0] ed, input string tag);
        acc(1'b0, m, el, 64'd0, ek, et, ed, tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (!rst && rsp_vld) begin
            if (q.size() == 0) begin
                check(1'b0, "R1 unexpected response", {62'd0, rsp_kind}, 64'd0);
            end else begin
                e = q.pop_front();
                check(rsp_kind == e.kind, {e.tag, " kind"}, {62'd0, rsp_kind}, {62'd0, e.kind});
                if (e.kind == K_RD)
                    check(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
                if (e.kind == K_TR) begin
                    check(rsp_trap_el == e.tel, {e.tag, " trap level R7"},
                          {62'd0, rsp_trap_el}, {62'd0, e.tel});
                    check(rsp_ec == 6'h18, {e.tag, " class R7"}, {58'd0, rsp_ec}, 64'h18);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rsp_vld == 0, "R12 reset rsp_vld", {63'd0, rsp_vld}, 64'd0);
        check(enabled_wr_warn == 0, "R12 reset warn", {63'd0, enabled_wr_warn}, 64'd0);

        rd(0, 3, K_RD, 0, 64'd0, "R12 idx0 reset");
        rd(2, 3, K_RD, 0, 64'h123, "R10 fixed idx2 reset");
        rd(11, 3, K_RD, 0, 64'd0, "R12 idx11 reset");

        acc(1, 0, 3, 64'hFFFF_FFFF_ABCD_5678, K_WR, 0, 0, "R8 write EL3");
        rd(0, 3, K_RD, 0, 64'h5678, "R9 masked readback");
        acc(1, 9, 3, 64'h0000_0000_0000_BEEF, K_WR, 0, 0, "R2 write idx9");
        rd(9, 1, K_RD, 0, 64'hBEEF, "R2 R5 read idx9 EL1");
        acc(1, 1, 2, 64'h55, K_UD, 0, 0, "R8 write below top level");
        rd(1, 3, K_RD, 0, 64'd0, "R8 refused write no effect");
        acc(1, 2, 3, 64'hAAAA, K_UD, 0, 0, "R10 write fixed");
        rd(2, 3, K_RD, 0, 64'h123, "R10 fixed unchanged");

        rd(12, 3, K_UD, 0, 0, "R2 out of range");
        rd(7, 3, K_UD, 0, 0, "R2 unimplemented");
        rd(15, 3, K_UD, 0, 0, "R2 top index");

        el3_trap_all = 1;
        rd(12, 0, K_UD, 0, 0, "R2 priority over trap");
        rd(0, 1, K_TR, 3, 0, "R5 EL3 trap from EL1");
        rd(0, 2, K_TR, 3, 0, "R6 EL3 trap from EL2");
        rd(0, 3, K_RD, 0, 64'h5678, "R6 EL3 read");
        el3_undef = 1;
        rd(0, 1, K_UD, 0, 0, "R5 EL3 undef variant");
        el3_undef_prio = 1; user_access_en = 0;
        rd(0, 0, K_UD, 0, 0, "R3 step1 beats user enable");
        el3_trap_all = 0; el3_undef = 0; el3_undef_prio = 0;

        rd(0, 0, K_TR, 1, 0, "R3 user enable to EL1");
        host_route = 1;
        rd(0, 0, K_TR, 2, 0, "R3 user enable routed EL2");
        rd(0, 1, K_RD, 0, 64'h5678, "R5 no user step at EL1");
        host_route = 0; user_access_en = 1;

        el2_trap_all = 1;
        rd(0, 0, K_TR, 2, 0, "R3 EL2 trap-all");
        rd(0, 1, K_TR, 2, 0, "R5 EL2 trap-all");
        rd(0, 2, K_RD, 0, 64'h5678, "R6 EL2 ignores EL2 trap");
        el2_enabled = 0;
        rd(0, 0, K_RD, 0, 64'h5678, "R3 EL2 disabled");
        el2_enabled = 1; el2_trap_all = 0;

        fgt_trap_vec = 16'h0001;
        rd(0, 0, K_TR, 2, 0, "R4 fgt EL0");
        rd(9, 0, K_RD, 0, 64'hBEEF, "R4 other index");
        el0_host = 1;
        rd(0, 0, K_RD, 0, 64'h5678, "R4 host mode EL0");
        rd(0, 1, K_TR, 2, 0, "R4 host ignored EL1");
        el0_host = 0; fgt_present = 0;
        rd(0, 1, K_RD, 0, 64'h5678, "R4 fgt absent");
        fgt_present = 1; el3_fgt_allow = 0;
        rd(0, 1, K_RD, 0, 64'h5678, "R4 EL3 disallows");
        el3_present = 0;
        rd(0, 1, K_TR, 2, 0, "R4 EL3 absent");
        el3_present = 1; el3_fgt_allow = 1; fgt_trap_vec = 16'd0;

        ctr_enable = 16'h0001;
        acc(1, 0, 3, 64'h1111, K_WR, 0, 0, "R11 write while running");
        check(enabled_wr_warn == 1, "R11 warn set", {63'd0, enabled_wr_warn}, 64'd1);
        rd(0, 3, K_RD, 0, 64'h5678, "R11 value kept");
        ctr_enable = 16'd0;
        acc(1, 0, 3, 64'h2222, K_WR, 0, 0, "R11 write after stop");
        rd(0, 3, K_RD, 0, 64'h2222, "R11 update after stop");
        check(enabled_wr_warn == 1, "R11 warn sticky", {63'd0, enabled_wr_warn}, 64'd1);

        el3_present = 0;
        acc(1, 3, 2, 64'h77, K_WR, 0, 0, "R8 top level EL2");
        rd(3, 2, K_RD, 0, 64'h77, "R8 readback EL2");
        acc(1, 3, 1, 64'h99, K_UD, 0, 0, "R8 EL1 not top");
        el2_present = 0;
        acc(1, 3, 1, 64'h88, K_WR, 0, 0, "R8 top level EL1");
        rd(3, 0, K_RD, 0, 64'h88, "R8 readback EL0");
        el2_present = 1; el3_present = 1;

        @(negedge clk);
        acc_op1 = 3'b010; acc_crm = 4'b1110; acc_op2 = 3'd0; acc_wr = 0; acc_vld = 1;
        @(negedge clk);
        acc_vld = 0;
        check(rsp_vld == 0, "R1 foreign encoding ignored", {63'd0, rsp_vld}, 64'd0);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(enabled_wr_warn == 0, "R12 warn cleared", {63'd0, enabled_wr_warn}, 64'd0);
        rd(0, 3, K_RD, 0, 64'd0, "R12 idx0 cleared");
        rd(2, 3, K_RD, 0, 64'h123, "R12 fixed kept");

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R1 missing responses", q.size(), 64'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule